// File: doc/BRIEF.md
# Host Register Port with Byte Parity

This block is a synchronous slave port through which an external host processor reads and writes a small bank of byte-wide registers. The data path is 8, 16 or 32 bits wide, set by a parameter. Each data byte travels with one parity bit, so the parity lane is 1, 2 or 4 bits wide. A host access covers a window of consecutive byte registers. Lane 0 carries the lowest register of the window.

The bank has four registers: control, status, a read-only device identifier and a general scratchpad. The block checks odd parity on writes and produces odd parity on read data. Parity checking and generation can be turned off. A write with a parity mismatch is dropped as a whole and sets a sticky error flag. A second, software-raised event can be set from the control register. Each pending event is masked by an enable bit in the control register and drives an interrupt line. The host can also poll the state of that line in the status register. Every register has a defined value straight out of reset, so the port works before any other logic is set up.

Top module: `hostreg_port`

## Requirements
- R1: After reset, control, status and scratchpad read as 0x00, `irq` is 0 and `rd_ack` is 0.
- R2: A read request (`sel`=1, `wr_en`=0) raises `rd_ack` for exactly the following cycle, with `rdata` registered at that edge. Lane i of `rdata` carries register (B+i). B is `addr` with its low log2(DATA_W/8) bits cleared. Register indices are: 0 control, 1 status, 2 identifier, 3 scratchpad.
- R3: A write request (`sel`=1, `wr_en`=1) that passes the parity check updates every writable register in its window at that clock edge. Lane i goes to register (B+i).
- R4: With `parity_on`=1, `rpar[i]` makes byte i of `rdata` together with that bit hold an odd number of ones. With `parity_on`=0, `rpar` is all zero.
- R5: With `parity_on`=1, a write on which any lane fails the odd-parity rule changes no register. Instead it sets status bit 0 (parity error).
- R6: With `parity_on`=0, `wpar` is ignored and every write is accepted.
- R7: The identifier register always reads the DEVICE_ID parameter and ignores writes.
- R8: Status bits 0 and 1 are cleared by writing 1 to them. Writing 0 leaves them unchanged. Status bits 6..2 read 0.
- R9: Writing control with bit 7 set sets status bit 1 (software event). Control bit 7 always reads 0. If the same write also clears status bit 1, the set wins.
- R10: Control bits 0 and 1 enable status bits 0 and 1. `irq` = (status0 AND control0) OR (status1 AND control1). Status bit 7 reads the current `irq` value. Control bits 6..2 read 0.
- R11: The scratchpad stores and returns any 8-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Access request this cycle |
| wr_en | input | 1 | 1 = write, 0 = read |
| addr | input | 2 | Byte register address; low bits below the lane count are ignored |
| wdata | input | DATA_W | Write data, lane i = byte i |
| wpar | input | DATA_W/8 | Odd parity bit per write byte |
| parity_on | input | 1 | Enables parity checking and generation |
| rdata | output | DATA_W | Registered read data |
| rpar | output | DATA_W/8 | Odd parity bit per read byte |
| rd_ack | output | 1 | Read data valid |
| irq | output | 1 | Interrupt to host |

## Verification
A write lands in the registers at the edge that samples the request, so the next cycle's `irq` and any later read already see it. Read data and `rd_ack` appear one edge after the read request. `rpar` follows `rdata` with no further delay. The bench drives every request just after a falling edge and samples at the next falling edge. Each result is therefore read exactly one rising edge after its cause, and the checks never race the clock. Expected bytes come from a small model in the bench that applies the requirements to every write, including the dropped ones.

// File: rtl/hostreg_pkg.sv
package hostreg_pkg;

    localparam int NUM_REGS = 4;
    localparam int REG_AW   = 2;
    localparam int BYTE_W   = 8;
    localparam int NUM_EV   = 2;

    localparam int EV_PERR  = 0;
    localparam int EV_SOFT  = 1;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [REG_AW-1:0] reg_addr_t;

    typedef enum logic [REG_AW-1:0] {
        RG_CTRL    = 2'd0,
        RG_STAT    = 2'd1,
        RG_IDENT   = 2'd2,
        RG_SCRATCH = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              kick;
        logic [4:0]        pad;
        logic [NUM_EV-1:0] ie;
    } ctrl_view_t;

    typedef struct packed {
        logic              irq;
        logic [4:0]        pad;
        logic [NUM_EV-1:0] pend;
    } stat_view_t;

    function automatic logic odd_bit(input byte_t b);
        return ~(^b);
    endfunction

    function automatic logic in_window(input reg_addr_t a, input reg_addr_t r, input int sh);
        return (a >> sh) == (r >> sh);
    endfunction

endpackage

// File: rtl/hostreg_parity.sv
module hostreg_parity
    import hostreg_pkg::*;
#(
    parameter int NB = 4
) (
    input  logic [NB*BYTE_W-1:0] wdata,
    input  logic [NB-1:0]        wpar,
    input  logic [NB*BYTE_W-1:0] rdata,
    input  logic                 parity_on,
    output logic                 wr_par_ok,
    output logic [NB-1:0]        rpar
);
    logic [NB-1:0] lane_bad;

    for (genvar i = 0; i < NB; i++) begin : g_lane
        assign lane_bad[i] = wpar[i] != odd_bit(wdata[i*BYTE_W +: BYTE_W]);
        assign rpar[i]     = parity_on & odd_bit(rdata[i*BYTE_W +: BYTE_W]);
    end

    assign wr_par_ok = !parity_on || (lane_bad == '0);

endmodule

// File: rtl/hostreg_window.sv
module hostreg_window
    import hostreg_pkg::*;
#(
    parameter int NB = 4
) (
    input  reg_addr_t                 addr,
    input  logic [NB*BYTE_W-1:0]      wdata,
    output logic [NUM_REGS-1:0]       hit,
    output byte_t [NUM_REGS-1:0]      wbyte,
    output reg_addr_t [NB-1:0]        lane_reg
);
    localparam int LANE_SH = (NB > 1) ? $clog2(NB) : 0;

    reg_addr_t base;
    assign base = reg_addr_t'((addr >> LANE_SH) << LANE_SH);

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        assign hit[r]   = in_window(addr, reg_addr_t'(r), LANE_SH);
        assign wbyte[r] = wdata[(r % NB)*BYTE_W +: BYTE_W];
    end

    for (genvar i = 0; i < NB; i++) begin : g_lane
        assign lane_reg[i] = base | reg_addr_t'(i);
    end

endmodule

// File: rtl/hostreg_bank.sv
module hostreg_bank
    import hostreg_pkg::*;
#(
    parameter byte_t DEVICE_ID = 8'h5A
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_go,
    input  logic                  perr_evt,
    input  logic [NUM_REGS-1:0]   hit,
    input  byte_t [NUM_REGS-1:0]  wbyte,
    output byte_t [NUM_REGS-1:0]  reg_rd,
    output logic                  irq
);
    logic [NUM_EV-1:0] ie_q;
    logic [NUM_EV-1:0] pend_q;
    logic [NUM_EV-1:0] pend_nxt;
    byte_t             scr_q;
    ctrl_view_t        ctrl_w;
    stat_view_t        stat_w;
    ctrl_view_t        ctrl_v;
    stat_view_t        stat_v;

    assign ctrl_w = ctrl_view_t'(wbyte[RG_CTRL]);
    assign stat_w = stat_view_t'(wbyte[RG_STAT]);

    always_comb begin
        pend_nxt = pend_q;
        if (wr_go && hit[RG_STAT])
            pend_nxt = pend_nxt & ~stat_w.pend;
        if (wr_go && hit[RG_CTRL] && ctrl_w.kick)
            pend_nxt[EV_SOFT] = 1'b1;
        if (perr_evt)
            pend_nxt[EV_PERR] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ie_q   <= '0;
            pend_q <= '0;
            scr_q  <= '0;
        end else begin
            pend_q <= pend_nxt;
            if (wr_go && hit[RG_CTRL])
                ie_q <= ctrl_w.ie;
            if (wr_go && hit[RG_SCRATCH])
                scr_q <= wbyte[RG_SCRATCH];
        end
    end

    assign irq = |(pend_q & ie_q);

    always_comb begin
        ctrl_v      = '0;
        ctrl_v.ie   = ie_q;
        stat_v      = '0;
        stat_v.pend = pend_q;
        stat_v.irq  = irq;
    end

    assign reg_rd[RG_CTRL]    = byte_t'(ctrl_v);
    assign reg_rd[RG_STAT]    = byte_t'(stat_v);
    assign reg_rd[RG_IDENT]   = DEVICE_ID;
    assign reg_rd[RG_SCRATCH] = scr_q;

    logic unused_bits;
    assign unused_bits = ^{ctrl_w.pad, stat_w.pad, stat_w.irq, wbyte[RG_IDENT], hit[RG_IDENT]};

endmodule

// File: rtl/hostreg_port.sv
module hostreg_port
    import hostreg_pkg::*;
#(
    parameter int    DATA_W    = 32,
    parameter byte_t DEVICE_ID = 8'h5A
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sel,
    input  logic                wr_en,
    input  logic [1:0]          addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W/8-1:0] wpar,
    input  logic                parity_on,
    output logic [DATA_W-1:0]   rdata,
    output logic [DATA_W/8-1:0] rpar,
    output logic                rd_ack,
    output logic                irq
);
    localparam int NB = DATA_W / BYTE_W;

    logic                  wr_req;
    logic                  rd_req;
    logic                  wr_par_ok;
    logic                  wr_go;
    logic                  perr_evt;
    logic [NUM_REGS-1:0]   hit;
    byte_t [NUM_REGS-1:0]  wbyte;
    byte_t [NUM_REGS-1:0]  reg_rd;
    reg_addr_t [NB-1:0]    lane_reg;
    logic [DATA_W-1:0]     rd_next;
    logic [DATA_W-1:0]     rdata_q;

    assign wr_req   = sel & wr_en;
    assign rd_req   = sel & ~wr_en;
    assign wr_go    = wr_req & wr_par_ok;
    assign perr_evt = wr_req & ~wr_par_ok;

    hostreg_window #(.NB(NB)) u_window (
        .addr     (addr),
        .wdata    (wdata),
        .hit      (hit),
        .wbyte    (wbyte),
        .lane_reg (lane_reg)
    );

    hostreg_parity #(.NB(NB)) u_parity (
        .wdata     (wdata),
        .wpar      (wpar),
        .rdata     (rdata_q),
        .parity_on (parity_on),
        .wr_par_ok (wr_par_ok),
        .rpar      (rpar)
    );

    hostreg_bank #(.DEVICE_ID(DEVICE_ID)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_go    (wr_go),
        .perr_evt (perr_evt),
        .hit      (hit),
        .wbyte    (wbyte),
        .reg_rd   (reg_rd),
        .irq      (irq)
    );

    for (genvar i = 0; i < NB; i++) begin : g_rdlane
        assign rd_next[i*BYTE_W +: BYTE_W] = reg_rd[lane_reg[i]];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ack  <= 1'b0;
            rdata_q <= '0;
        end else begin
            rd_ack <= rd_req;
            if (rd_req)
                rdata_q <= rd_next;
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/hostreg_chk.sv
module hostreg_chk
    import hostreg_pkg::*;
#(
    parameter int NB = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 sel,
    input logic                 wr_en,
    input logic [NB*8-1:0]      wdata,
    input logic [NB-1:0]        wpar,
    input logic                 parity_on,
    input logic [NB*8-1:0]      rdata,
    input logic [NB-1:0]        rpar,
    input logic                 rd_ack,
    input logic                 irq,
    input byte_t [NUM_REGS-1:0] reg_rd
);
    logic [NB-1:0] in_bad;
    logic [NB-1:0] out_odd;

    for (genvar i = 0; i < NB; i++) begin : g_l
        assign in_bad[i]  = (wpar[i] == ^wdata[i*8 +: 8]);
        assign out_odd[i] = ^{rdata[i*8 +: 8], rpar[i]};
    end

    AST_READ_ACK: assert property (@(posedge clk) disable iff (rst) (sel && !wr_en) |=> rd_ack); // R2
    AST_ACK_ONLY_READ: assert property (@(posedge clk) disable iff (rst) !(sel && !wr_en) |=> !rd_ack); // R2
    AST_RPAR_ODD: assert property (@(posedge clk) disable iff (rst) (rd_ack && parity_on) |-> (&out_odd)); // R4
    AST_RPAR_QUIET: assert property (@(posedge clk) disable iff (rst) !parity_on |-> (rpar == '0)); // R4
    AST_BAD_SETS_PERR: assert property (@(posedge clk) disable iff (rst) (sel && wr_en && parity_on && (in_bad != '0)) |=> reg_rd[RG_STAT][EV_PERR]); // R5
    AST_BAD_KEEPS_SCR: assert property (@(posedge clk) disable iff (rst) (sel && wr_en && parity_on && (in_bad != '0)) |=> $stable(reg_rd[RG_SCRATCH])); // R5
    AST_IRQ_FROM_WRITE: assert property (@(posedge clk) disable iff (rst) $rose(irq) |-> $past(sel && wr_en)); // R10

endmodule

bind hostreg_port hostreg_chk #(.NB(NB)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sel       (sel),
    .wr_en     (wr_en),
    .wdata     (wdata),
    .wpar      (wpar),
    .parity_on (parity_on),
    .rdata     (rdata),
    .rpar      (rpar),
    .rd_ack    (rd_ack),
    .irq       (irq),
    .reg_rd    (reg_rd)
);

// File: tb/hostreg_port_tb.sv
module hostreg_port_tb;
    localparam int   CLK_PERIOD = 10;
    localparam int   DW = 16;
    localparam int   NBL = DW / 8;
    localparam logic [7:0] ID = 8'hC3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sel = 1'b0, wr_en = 1'b0, parity_on = 1'b1;
    logic [1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [NBL-1:0] wpar = '0;
    logic [DW-1:0] rdata;
    logic [NBL-1:0] rpar;
    logic rd_ack, irq;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    logic [1:0] m_ie = '0, m_pend = '0;
    logic [7:0] m_scr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hostreg_port #(.DATA_W(DW), .DEVICE_ID(ID)) u_dut (
        .clk(clk), .rst(rst), .sel(sel), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .wpar(wpar), .parity_on(parity_on),
        .rdata(rdata), .rpar(rpar), .rd_ack(rd_ack), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic par_of(input logic [7:0] b);
        return ($countones(b) % 2) == 0;
    endfunction

    function automatic logic m_irq();
        return |(m_pend & m_ie);
    endfunction

    function automatic logic [7:0] m_byte(input int r);
        case (r)
            0: return {6'b0, m_ie};
            1: return {m_irq(), 5'b0, m_pend};
            2: return ID;
            default: return m_scr;
        endcase
    endfunction

    task automatic model_write(input logic [1:0] a, input logic [DW-1:0] d, input logic [NBL-1:0] bad);
        int base;
        logic [1:0] np;
        if (parity_on && bad != '0) begin
            m_pend[0] = 1'b1;
            return;
        end
        base = (int'(a) / NBL) * NBL;
        np = m_pend;
        for (int i = 0; i < NBL; i++) begin
            logic [7:0] b;
            b = d[i*8 +: 8];
            case (base + i)
                0: m_ie = b[1:0];
                1: np = np & ~b[1:0];
                3: m_scr = b;
                default: ;
            endcase
        end
        for (int i = 0; i < NBL; i++)
            if (base + i == 0 && d[i*8+7]) np[1] = 1'b1;
        m_pend = np;
    endtask

    task automatic do_write(input logic [1:0] a, input logic [DW-1:0] d, input logic [NBL-1:0] bad);
        @(negedge clk);
        sel = 1'b1; wr_en = 1'b1; addr = a; wdata = d;
        for (int i = 0; i < NBL; i++) wpar[i] = par_of(d[i*8 +: 8]) ^ bad[i];
        @(negedge clk);
        sel = 1'b0; wr_en = 1'b0;
        model_write(a, d, bad);
    endtask

    task automatic do_read(input logic [1:0] a, input string req);
        int base;
        logic [DW-1:0] exp_d;
        logic [NBL-1:0] exp_p;
        @(negedge clk);
        sel = 1'b1; wr_en = 1'b0; addr = a;
        @(negedge clk);
        sel = 1'b0;
        base = (int'(a) / NBL) * NBL;
        for (int i = 0; i < NBL; i++) begin
            exp_d[i*8 +: 8] = m_byte(base + i);
            exp_p[i] = parity_on ? par_of(exp_d[i*8 +: 8]) : 1'b0;
        end
        chk({req, " R2 ack"}, 32'(rd_ack), 32'd1);
        chk({req, " data"}, 32'(rdata), 32'(exp_d));
        chk({req, " R4 rpar"}, 32'(rpar), 32'(exp_p));
        @(negedge clk);
        chk({req, " R2 ack drop"}, 32'(rd_ack), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1 rd_ack", 32'(rd_ack), 32'd0);
        chk("R1 irq", 32'(irq), 32'd0);
        do_read(2'd0, "R1 ctrl/status");
        do_read(2'd3, "R1 R7 id/scratch");

        // R11 R3 R7: scratch sweep, id write ignored, low addr bit ignored
        for (int v = 0; v < 256; v++) begin
            do_write(2'(2 + (v % 2)), {8'(v), ~8'(v)}, 2'b00);
            do_read(2'(3 - (v % 2)), "R11 R3 R7 scratch");
        end

        // R5: each bad-lane mask drops the write and sets the error flag
        for (int m = 1; m < 4; m++) begin
            do_write(2'd2, {8'h3C ^ 8'(m), 8'h00}, 2'(m));
            do_read(2'd2, "R5 dropped write");
            chk("R5 perr", 32'(u_dut.rd_ack == 1'b0 ? m_pend[0] : 1'b0), 32'd1);
            do_read(2'd0, "R5 status");
            do_write(2'd0, {8'h01, 8'h00}, 2'b00);
            do_read(2'd1, "R8 clear perr");
        end

        // R6: parity off accepts wrong wpar, rpar forced zero
        parity_on = 1'b0;
        do_write(2'd2, {8'h99, 8'h00}, 2'b11);
        do_read(2'd2, "R6 R4 parity off");
        parity_on = 1'b1;
        do_read(2'd0, "R6 no perr");

        // R10 R9 R8: interrupt over every enable/event pairing
        for (int ie = 0; ie < 4; ie++) begin
            for (int ev = 0; ev < 4; ev++) begin
                do_write(2'd0, {8'h03, 8'h00}, 2'b00);
                if (ev[1]) do_write(2'd0, {8'h00, 8'h80}, 2'b00);
                if (ev[0]) do_write(2'd0, {8'h00, 8'h00}, 2'b01);
                do_write(2'd0, {8'h00, 8'(ie)}, 2'b00);
                chk("R10 irq", 32'(irq), 32'(|(2'(ev) & 2'(ie))));
                do_read(2'd0, "R10 R9 poll");
            end
        end

        // R9: set beats clear in the same write
        do_write(2'd0, {8'h02, 8'h82}, 2'b00);
        chk("R9 set wins irq", 32'(irq), 32'd1);
        do_read(2'd0, "R9 set wins");
        // R8: writing zeros keeps pending bits
        do_write(2'd0, {8'h00, 8'h02}, 2'b00);
        do_read(2'd1, "R8 zero write keeps");
        do_write(2'd0, {8'h03, 8'h00}, 2'b00);
        chk("R8 R10 cleared irq", 32'(irq), 32'd0);
        do_read(2'd0, "R8 cleared");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule